// File: doc/BRIEF.md
# Packed Eight-Channel Serial Frame Port

This block moves eight transmit channels and eight receive channels over a single pair of serial data pins. Every frame lasts exactly 256 bit-clock periods and is divided into eight 32-bit slots. Each 24-bit sample sits MSB-first at the top of its slot, with eight zero pad bits below it. Slots 0 to 3 form the left half of the frame and slots 4 to 7 the right half. The frame clock is low during the left half and high during the right half.

A host writes transmit samples one channel at a time into holding registers. The port copies all eight into its shift path at the start of each frame, so a write that lands mid-frame only takes effect from the next frame. Received samples become readable as a set when the last bit of a frame has been captured, and a one-cycle done strobe marks that moment. A start strobe marks the cycle in which bit 0 of a new frame first appears on the data-out pin.

In master mode the port makes the bit clock and the frame clock itself, from a system clock that runs at `CLK_PER_BIT` times the bit rate. In slave mode it follows an external bit clock and frame clock, after resynchronising them to the system clock. A static configuration input selects the mode.

Top module: `tdm_packed_port`

## Requirements
- R1: While `rst` is high, `bclkOut`, `sdOut`, `frameStart` and `frameDone` are 0, every `rdData` channel reads 0, and in master mode `lrOut` is 1 (the bit counter is parked on the last bit of a frame).
- R2: In master mode, after reset release, `bclkOut` is low for `CLK_PER_BIT/2` system clocks and then high for `CLK_PER_BIT/2`, repeating. The bit position advances only on a falling `bclkOut`.
- R3: A frame is 256 bit periods, numbered 0 to 255. In master mode `lrOut` is 0 for bits 0 to 127 and 1 for bits 128 to 255, so it changes only at bit 0 and bit 128. The first frame after reset begins at the first falling edge of `bclkOut`.
- R4: Bit n of the frame belongs to slot n/32, which carries channel n/32. Its first 24 bits are that channel's sample, MSB first, and its last 8 bits are 0. `sdOut` changes only on a bit-clock falling edge.
- R5: `sdIn` is sampled on each rising bit-clock edge. After a frame, channel k reads back the 24 bits received at positions 32k to 32k+23, MSB first. The 8 pad bits of each slot are ignored.
- R6: A host write (`wrEn`, `wrChan`, `wrData`) goes to a holding register. The transmit image is taken from the holding registers at the falling edge that starts a frame, so a write at any point in a frame, including the cycle of that edge, first shows up in the following frame.
- R7: `frameStart` is high for exactly one system clock: the first cycle in which bit 0 of a frame is on `sdOut`.
- R8: `frameDone` is high for exactly one system clock, right after the edge that samples bit 255. At that same edge the readback registers take the new frame. A frame whose start the port has not seen since reset gives no `frameDone`.
- R9: In slave mode `bclkOut` and `lrOut` stay 0. `bclkIn` and `lrIn` pass through a two-stage synchroniser, and the port acts on their edges no more than three system clocks later. A frame begins at a `bclkIn` falling edge at which `lrIn` is 0, provided `lrIn` was 1 at the previous falling edge.
- R10: The readback registers hold the last completed frame until the next `frameDone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| master | input | 1 | 1: port generates bit and frame clocks; 0: follows external clocks |
| bclkIn | input | 1 | External bit clock (slave mode) |
| lrIn | input | 1 | External frame clock (slave mode) |
| bclkOut | output | 1 | Generated bit clock (master mode, else 0) |
| lrOut | output | 1 | Generated frame clock, low in left half (master mode, else 0) |
| sdIn | input | 1 | Serial receive data |
| sdOut | output | 1 | Serial transmit data |
| wrEn | input | 1 | Host write strobe for a transmit channel |
| wrChan | input | 3 | Transmit channel written |
| wrData | input | 24 | Transmit sample |
| rdChan | input | 3 | Receive channel selected for readback |
| rdData | output | 24 | Received sample of the selected channel |
| frameStart | output | 1 | One-cycle pulse when bit 0 of a frame is on `sdOut` |
| frameDone | output | 1 | One-cycle pulse when a received frame is readable |

## Verification
The assertions take `master` to be constant outside reset. In slave mode they also take the external clocks to be slow enough that each `bclkIn` level lasts several system clocks, so the synchronised rising and falling edges never fall in the same cycle. The stimulus changes `master` only while reset is held. In slave mode it holds each external bit-clock level for eight system clocks and changes `lrIn` and `sdIn` only together with a falling `bclkIn`. That keeps the data stable well before the port samples it.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic rise;     // bit-clock rising edge: sample sdIn
    logic fall;     // bit-clock falling edge: advance transmit bit
    logic load;     // falling edge that opens a new frame
    logic publish;  // rising edge of the last bit of a seen frame
  } tdmStrobe_t;
endpackage

// File: rtl/tdm_ctrl.sv
module tdm_ctrl
  import tdm_pkg::*;
#(
  parameter int FRAME_BITS  = 256,
  parameter int CLK_PER_BIT = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       master,
  input  logic       bclkIn,
  input  logic       lrIn,
  output logic       bclkOut,
  output logic       lrOut,
  output logic       frameStart,
  output logic       frameDone,
  output tdmStrobe_t strobe
);
  localparam int CNT_W    = $clog2(FRAME_BITS);
  localparam int DIV_W    = $clog2(CLK_PER_BIT);
  localparam int HALF_DIV = CLK_PER_BIT / 2;
  localparam int HALF_FRM = FRAME_BITS / 2;

  logic [DIV_W-1:0] divCnt;
  logic             bclkGen;
  logic [2:0]       bSync;
  logic [1:0]       lSync;
  logic             lrAtFall;
  logic [CNT_W-1:0] bitCnt;
  logic             seenStart;
  logic             riseTick, fallTick, frameEdge, lastBit;

  always_comb begin
    lastBit = (bitCnt == CNT_W'(FRAME_BITS - 1));
    if (master) begin
      riseTick  = (divCnt == DIV_W'(HALF_DIV - 1));
      fallTick  = (divCnt == DIV_W'(CLK_PER_BIT - 1));
      frameEdge = fallTick && lastBit;
    end else begin
      riseTick  = bSync[1] && !bSync[2];
      fallTick  = !bSync[1] && bSync[2];
      frameEdge = fallTick && lrAtFall && !lSync[1];
    end
    strobe.rise    = riseTick;
    strobe.fall    = fallTick;
    strobe.load    = frameEdge;
    strobe.publish = riseTick && lastBit && seenStart;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt     <= '0;
      bclkGen    <= 1'b0;
      bSync      <= '0;
      lSync      <= '0;
      lrAtFall   <= 1'b0;
      bitCnt     <= '1;
      seenStart  <= 1'b0;
      frameStart <= 1'b0;
      frameDone  <= 1'b0;
    end else begin
      bSync <= {bSync[1:0], bclkIn};
      lSync <= {lSync[0], lrIn};
      if (master) begin
        divCnt <= fallTick ? '0 : divCnt + 1'b1;
        if (riseTick) bclkGen <= 1'b1;
        else if (fallTick) bclkGen <= 1'b0;
      end else begin
        divCnt  <= '0;
        bclkGen <= 1'b0;
      end
      if (fallTick) begin
        bitCnt   <= frameEdge ? '0 : bitCnt + 1'b1;
        lrAtFall <= lSync[1];
        if (frameEdge) seenStart <= 1'b1;
      end
      frameStart <= frameEdge;
      frameDone  <= strobe.publish;
    end
  end

  assign bclkOut = bclkGen;
  assign lrOut   = master && bitCnt[CNT_W-1];

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    frameDone |=> !frameDone); // R8
  AST_START_AT_BIT0: assert property (@(posedge clk) disable iff (rst)
    frameStart |-> (bitCnt == '0)); // R7
  AST_LR_EDGE_AT_HALF: assert property (@(posedge clk) disable iff (rst)
    (master && !$stable(lrOut)) |-> (bitCnt == '0 || bitCnt == CNT_W'(HALF_FRM))); // R3
  AST_ADVANCE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (master && !$stable(bitCnt)) |-> $fell(bclkOut)); // R2
  AST_START_LEFT_HALF: assert property (@(posedge clk) disable iff (rst)
    (master && frameStart) |-> (!lrOut && $past(lrOut))); // R3
endmodule

// File: rtl/tdm_datapath.sv
module tdm_datapath
  import tdm_pkg::*;
#(
  parameter int CHANNELS    = 8,
  parameter int SLOT_BITS   = 32,
  parameter int SAMPLE_BITS = 24
) (
  input  logic                           clk,
  input  logic                           rst,
  input  tdmStrobe_t                     strobe,
  input  logic                           sdIn,
  output logic                           sdOut,
  input  logic                           wrEn,
  input  logic [$clog2(CHANNELS)-1:0]    wrChan,
  input  logic [SAMPLE_BITS-1:0]         wrData,
  input  logic [$clog2(CHANNELS)-1:0]    rdChan,
  output logic [SAMPLE_BITS-1:0]         rdData
);
  localparam int FRAME_BITS = CHANNELS * SLOT_BITS;
  localparam int PAD_BITS   = SLOT_BITS - SAMPLE_BITS;

  logic [SAMPLE_BITS-1:0] holdReg [CHANNELS];
  logic [SAMPLE_BITS-1:0] rxReg   [CHANNELS];
  logic [FRAME_BITS-1:0]  txImage, txShift, rxShift, rxNext;

  // Slot g of the image: sample left-aligned, pad bits zero
  for (genvar g = 0; g < CHANNELS; g++) begin : gSlot
    assign txImage[FRAME_BITS-1-g*SLOT_BITS -: SLOT_BITS] =
      SLOT_BITS'(holdReg[g]) << PAD_BITS;
  end

  assign rxNext = {rxShift[FRAME_BITS-2:0], sdIn};

  always_ff @(posedge clk) begin
    if (rst) begin
      txShift <= '0;
      rxShift <= '0;
      for (int k = 0; k < CHANNELS; k++) begin
        holdReg[k] <= '0;
        rxReg[k]   <= '0;
      end
    end else begin
      if (wrEn) holdReg[wrChan] <= wrData;
      if (strobe.fall) txShift <= strobe.load ? txImage : (txShift << 1);
      if (strobe.rise) rxShift <= rxNext;
      if (strobe.publish) begin
        for (int k = 0; k < CHANNELS; k++)
          rxReg[k] <= rxNext[FRAME_BITS-1-k*SLOT_BITS -: SAMPLE_BITS];
      end
    end
  end

  assign sdOut  = txShift[FRAME_BITS-1];
  assign rdData = rxReg[rdChan];

  AST_SD_CHANGES_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$past(strobe.fall) |-> $stable(sdOut)); // R4
endmodule

// File: rtl/tdm_packed_port.sv
module tdm_packed_port
  import tdm_pkg::*;
#(
  parameter int CHANNELS    = 8,
  parameter int SLOT_BITS   = 32,
  parameter int SAMPLE_BITS = 24,
  parameter int CLK_PER_BIT = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        master,
  input  logic                        bclkIn,
  input  logic                        lrIn,
  output logic                        bclkOut,
  output logic                        lrOut,
  input  logic                        sdIn,
  output logic                        sdOut,
  input  logic                        wrEn,
  input  logic [$clog2(CHANNELS)-1:0] wrChan,
  input  logic [SAMPLE_BITS-1:0]      wrData,
  input  logic [$clog2(CHANNELS)-1:0] rdChan,
  output logic [SAMPLE_BITS-1:0]      rdData,
  output logic                        frameStart,
  output logic                        frameDone
);
  localparam int FRAME_BITS = CHANNELS * SLOT_BITS;

  tdmStrobe_t strobe;

  tdm_ctrl #(.FRAME_BITS(FRAME_BITS), .CLK_PER_BIT(CLK_PER_BIT)) u_ctrl (
    .clk(clk), .rst(rst), .master(master), .bclkIn(bclkIn), .lrIn(lrIn),
    .bclkOut(bclkOut), .lrOut(lrOut), .frameStart(frameStart),
    .frameDone(frameDone), .strobe(strobe)
  );

  tdm_datapath #(.CHANNELS(CHANNELS), .SLOT_BITS(SLOT_BITS),
                 .SAMPLE_BITS(SAMPLE_BITS)) u_datapath (
    .clk(clk), .rst(rst), .strobe(strobe), .sdIn(sdIn), .sdOut(sdOut),
    .wrEn(wrEn), .wrChan(wrChan), .wrData(wrData),
    .rdChan(rdChan), .rdData(rdData)
  );
endmodule

// File: tb/tdm_packed_port_bench.sv
module tdm_packed_port_bench;
  localparam int DIV = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, master = 1'b1, bclkIn = 1'b0, lrIn = 1'b1, sdIn = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrChan = '0, rdChan = '0;
  logic [23:0] wrData = '0;
  logic bclkOut, lrOut, sdOut, frameStart, frameDone;
  logic [23:0] rdData;

  tdm_packed_port #(.CLK_PER_BIT(DIV)) u_tdm_packed_port (
    .clk(clk), .rst(rst), .master(master), .bclkIn(bclkIn), .lrIn(lrIn),
    .bclkOut(bclkOut), .lrOut(lrOut), .sdIn(sdIn), .sdOut(sdOut),
    .wrEn(wrEn), .wrChan(wrChan), .wrData(wrData), .rdChan(rdChan),
    .rdData(rdData), .frameStart(frameStart), .frameDone(frameDone)
  );

  int checks = 0, fails = 0, cyc = 0;
  int doneCnt = 0, startCnt = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      finishRun();
    end
  end

  // Observation counters for slave phase
  always @(negedge clk) begin
    if (!rst && frameDone)  doneCnt++;
    if (!rst && frameStart) startCnt++;
  end

  // ---------------- behavioural reference (master mode) ----------------
  bit modelOn = 0;
  int mDiv, mBit, frameNo;
  bit mBclk, mSeen, mStart, mDone;
  logic [255:0] mSnap, rxCur, expRx;
  logic [23:0] hostM [8];

  function automatic logic [255:0] packHost();
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[255-32*k -: 32] = {hostM[k], 8'h00};
    return v;
  endfunction

  function automatic logic [255:0] genRx(input int f);
    logic [255:0] v;
    for (int k = 0; k < 8; k++)
      v[255-32*k -: 32] = {8'(f*37 + k*11), 8'(k*53 + 3), 8'(f ^ k ^ 8'h5A), 8'(f*k + 77)};
    return v;
  endfunction

  always @(posedge clk) begin
    if (modelOn && !rst) begin
      bit riseE, fallE;
      riseE = (mDiv == DIV/2 - 1);
      fallE = (mDiv == DIV - 1);
      mDone = riseE && mBit == 255 && mSeen;
      if (mDone) expRx = rxCur;
      mStart = 0;
      if (riseE) mBclk = 1;
      if (fallE) begin
        mBclk = 0;
        mBit = (mBit + 1) % 256;
        if (mBit == 0) begin
          mStart = 1; mSeen = 1; mSnap = packHost();
          frameNo++; rxCur = genRx(frameNo);
        end
      end
      if (wrEn) hostM[wrChan] = wrData;
      mDiv = (mDiv + 1) % DIV;
    end
  end

  logic [255:0] txS, rxS;
  logic [23:0] sv [8];

  initial begin
    // ---------------- master phase ----------------
    mDiv = 0; mBit = 255; mBclk = 0; mSeen = 0; mStart = 0; mDone = 0;
    frameNo = 0; mSnap = '0; rxCur = '0; expRx = '0;
    for (int k = 0; k < 8; k++) hostM[k] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 bclkOut", bclkOut, 0);
    chk("R1 lrOut", lrOut, 1);
    chk("R1 sdOut", sdOut, 0);
    chk("R1 frameStart", frameStart, 0);
    chk("R1 frameDone", frameDone, 0);
    chk("R1 rdData", rdData, 0);
    rst = 1'b0; modelOn = 1;
    for (int i = 1; i <= 4*512 + 40; i++) begin
      @(negedge clk);
      chk("R2 bclkOut", bclkOut, mBclk);
      chk("R3 lrOut", lrOut, (mBit >= 128));
      chk("R4 R6 sdOut", sdOut, mSnap[255 - mBit]);
      chk("R7 frameStart", frameStart, mStart);
      chk("R8 frameDone", frameDone, mDone);
      chk("R5 R10 rdData", rdData, expRx[255 - 32*rdChan -: 24]);
      rdChan = 3'(i % 8);
      sdIn = rxCur[255 - mBit];
      wrEn = 1'b0;
      if (i <= 8) begin
        wrEn = 1'b1; wrChan = 3'(i - 1); wrData = 24'h800001 ^ 24'(i * 24'h1357AB);
      end else if (i == 700) begin
        wrEn = 1'b1; wrChan = 3'd2; wrData = 24'hC0FFEE;   // R6 mid-frame write
      end else if (i == 760) begin
        wrEn = 1'b1; wrChan = 3'd7; wrData = 24'h7FFFFF;
      end else if (frameNo == 2 && mBit == 255 && mDiv == DIV - 1) begin
        wrEn = 1'b1; wrChan = 3'd5; wrData = 24'hA5A5A5;   // R6 write on load edge
      end
    end
    wrEn = 1'b0;
    chk("R8 frames done", doneCnt, 4);

    // ---------------- slave phase ----------------
    modelOn = 0;
    @(negedge clk);
    rst = 1'b1; master = 1'b0; bclkIn = 1'b0; lrIn = 1'b1; sdIn = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 8; k++) begin
      sv[k] = 24'h00F00F + 24'(k * 24'h111111);
      @(negedge clk);
      wrEn = 1'b1; wrChan = 3'(k); wrData = sv[k];
    end
    @(negedge clk);
    wrEn = 1'b0;
    for (int k = 0; k < 8; k++) txS[255-32*k -: 32] = {sv[k], 8'h00};
    doneCnt = 0; startCnt = 0;
    // preamble: one bit with frame clock high
    bclkIn = 1'b1; repeat (8) @(negedge clk);
    bclkIn = 1'b0; repeat (8) @(negedge clk);
    bclkIn = 1'b1; repeat (8) @(negedge clk);
    chk("R8 no done before a seen start", doneCnt, 0);
    for (int f = 1; f <= 2; f++) begin
      rxS = genRx(f + 10);
      for (int b = 0; b < 256; b++) begin
        bclkIn = 1'b0; lrIn = (b >= 128); sdIn = rxS[255 - b];
        repeat (7) begin
          @(negedge clk);
          chk("R9 bclkOut low", bclkOut, 0);
          chk("R9 lrOut low", lrOut, 0);
        end
        chk("R4 R9 slave sdOut", sdOut, txS[255 - b]);
        @(negedge clk);
        bclkIn = 1'b1;
        repeat (8) @(negedge clk);
      end
      chk("R8 slave frameDone count", doneCnt, f);
      chk("R7 slave frameStart count", startCnt, f);
      for (int k = 0; k < 8; k++) begin
        rdChan = 3'(k);
        @(negedge clk);
        chk("R5 slave rdData", rdData, rxS[255 - 32*k -: 24]);
      end
    end
    finishRun();
  end
endmodule